// File: doc/BRIEF.md
# Burst-Limited DMA Bus Requester

This block decides when a DMA engine raises its request for a shared host bus, and how many data transfers it may make once the bus is granted. A request is launched only when the DMA FIFO has room for a whole burst, or has a whole burst waiting, depending on the transfer direction. Alignment cleanup at the start or end of a transfer may also launch a request, and in that case a shorter run of transfers is allowed.

An 8-bit mode register holds a two-bit burst code and six single-bit DMA options. The burst code caps the transfers made in one bus ownership. The cap counts every completed transfer, however back-to-back and burst cycles are mixed inside that ownership. When the last allowed transfer completes, the request is released and a one-cycle end-of-ownership pulse is given. A fixed fairness gap then keeps the request off for four clocks. If the grant is taken away in the middle of a burst, transfers stop at once. The request stays up, and the unused part of the count is carried into the next grant.

Top module: `dma_bus_requester`

## Requirements
- R1: After a synchronous reset, bus_req_n is 1, xfer_en is 0, own_end is 0 and mode_q reads 8'h00.
- R2: A cycle with mode_wr high stores mode_wdata into the mode register, which reads back on mode_q. Bits 7:6 are the burst code. Bits 5..0 are, from bit 5 down: source I/O select, destination I/O select, read-line enable, read-multiple enable, burst opcode fetch and manual start.
- R3: Burst codes 0, 1, 2 and 3 allow 2, 4, 8 and 16 transfers per ownership. A transfer completes on a clock edge where xfer_en and xfer_done are both 1.
- R4: Without cleanup, a request is launched only when the selected FIFO count is at least the burst size. The selected count is fifo_free when xfer_dir is 0 and fifo_fill when xfer_dir is 1. Otherwise bus_req_n stays 1.
- R5: While clean_sof or clean_eof is 1 and clean_len is nonzero, a request is launched whatever the FIFO counts are. That ownership carries the smaller of clean_len and the burst size.
- R6: xfer_en is 1 exactly while the block owns the bus and bus_gnt is 1. While the request waits for a grant, xfer_en is 0.
- R7: In the cycle after the edge where the last allowed transfer completes, bus_req_n is 1 and own_end is 1 for that one cycle only.
- R8: bus_req_n stays 1 for exactly four cycles from the own_end cycle. If the launch condition holds when the gap ends, the request returns in the fifth cycle.
- R9: If bus_gnt falls in the middle of a burst, xfer_en falls in the same cycle and bus_req_n stays 0. After the next grant only the remaining transfers are made, so one ownership totals the burst size and ends with a single own_end.
- R10: The transfer count is fixed when the request is launched. A mode write during an ownership does not change the count of that ownership.
- R11: An xfer_done pulse while xfer_en is 0 does not count as a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| mode_q | output | 8 | Mode register contents |
| xfer_dir | input | 1 | 0: bus reads into FIFO (use free space), 1: bus writes from FIFO (use fill level) |
| fifo_free | input | FIFO_W | Free FIFO entries |
| fifo_fill | input | FIFO_W | Filled FIFO entries |
| clean_sof | input | 1 | Start-of-transfer alignment cleanup pending |
| clean_eof | input | 1 | End-of-transfer alignment cleanup pending |
| clean_len | input | 5 | Transfers needed by the cleanup |
| bus_gnt | input | 1 | Bus grant |
| xfer_done | input | 1 | Transfer completion strobe |
| bus_req_n | output | 1 | Active-low bus request |
| xfer_en | output | 1 | Transfers may run this cycle |
| own_end | output | 1 | One-cycle end-of-ownership pulse |

## Verification
The assertions take for granted that bus_gnt is raised only in answer to an asserted request. They also take for granted that inputs change away from the rising edge, so that a transfer counts exactly when xfer_en and xfer_done meet at an edge. The bench's bus model derives the grant from the request it sees just after each edge, and it withholds the grant only through one control flag. FIFO counts, cleanup inputs and mode writes are changed by the driver a fixed delay after the edge. FIFO counts are dropped to zero during the gap after each expected ownership, so no request is launched that the scoreboard does not expect.

// File: rtl/brq_pkg.sv
package brq_pkg;

    localparam int CODE_W    = 2;
    localparam int MIN_LOG2  = 1;
    localparam int MAX_BURST = 1 << (MIN_LOG2 + (1 << CODE_W) - 1);
    localparam int CNT_W     = $clog2(MAX_BURST + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic [CODE_W-1:0] burst_code;
        logic              src_io_sel;
        logic              dst_io_sel;
        logic              rd_line_en;
        logic              rd_mult_en;
        logic              fetch_burst;
        logic              manual_go;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef enum logic [1:0] {
        RQ_IDLE = 2'd0,
        RQ_WAIT = 2'd1,
        RQ_OWN  = 2'd2,
        RQ_GAP  = 2'd3
    } rq_state_t;

    function automatic cnt_t burst_of(input logic [CODE_W-1:0] code);
        return cnt_t'(1) << (MIN_LOG2 + int'(code));
    endfunction

    function automatic cnt_t min_cnt(input cnt_t a, input cnt_t b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/brq_mode_reg.sv
module brq_mode_reg
    import brq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [MODE_W-1:0] wdata,
    output mode_t             mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
        end else if (wr) begin
            mode <= mode_t'(wdata);
        end
    end
endmodule

// File: rtl/brq_launch.sv
module brq_launch
    import brq_pkg::*;
#(
    parameter int FIFO_W = 6
) (
    input  logic [CODE_W-1:0] burst_code,
    input  logic              dir,
    input  logic [FIFO_W-1:0] free_cnt,
    input  logic [FIFO_W-1:0] fill_cnt,
    input  logic              clean_sof,
    input  logic              clean_eof,
    input  cnt_t              clean_len,
    output logic              go,
    output cnt_t              go_cnt
);
    cnt_t              burst;
    logic [FIFO_W-1:0] space;
    logic              cleaning;
    logic              room;

    always_comb begin
        burst    = burst_of(burst_code);
        space    = dir ? fill_cnt : free_cnt;
        room     = 32'(space) >= 32'(burst);
        cleaning = (clean_sof || clean_eof) && (clean_len != '0);
        if (cleaning) begin
            go     = 1'b1;
            go_cnt = min_cnt(clean_len, burst);
        end else begin
            go     = room;
            go_cnt = burst;
        end
    end
endmodule

// File: rtl/brq_gap_timer.sv
module brq_gap_timer #(
    parameter int GAP_CLKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic expired
);
    localparam int GW = $clog2(GAP_CLKS + 1);

    logic [GW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (start) begin
            left <= GW'(GAP_CLKS - 1);
        end else if (left != '0) begin
            left <= left - 1'b1;
        end
    end

    assign expired = (left == '0);
endmodule

// File: rtl/dma_bus_requester.sv
module dma_bus_requester
    import brq_pkg::*;
#(
    parameter int FIFO_W   = 6,
    parameter int GAP_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [7:0]        mode_wdata,
    output logic [7:0]        mode_q,
    input  logic              xfer_dir,
    input  logic [FIFO_W-1:0] fifo_free,
    input  logic [FIFO_W-1:0] fifo_fill,
    input  logic              clean_sof,
    input  logic              clean_eof,
    input  logic [4:0]        clean_len,
    input  logic              bus_gnt,
    input  logic              xfer_done,
    output logic              bus_req_n,
    output logic              xfer_en,
    output logic              own_end
);
    mode_t     mode;
    rq_state_t state;
    cnt_t      remain;
    cnt_t      go_cnt;
    logic      go;
    logic      gap_done;
    logic      beat;
    logic      last_beat;

    brq_mode_reg u_mode (
        .clk   (clk),
        .rst   (rst),
        .wr    (mode_wr),
        .wdata (mode_wdata),
        .mode  (mode)
    );

    brq_launch #(.FIFO_W(FIFO_W)) u_launch (
        .burst_code (mode.burst_code),
        .dir        (xfer_dir),
        .free_cnt   (fifo_free),
        .fill_cnt   (fifo_fill),
        .clean_sof  (clean_sof),
        .clean_eof  (clean_eof),
        .clean_len  (cnt_t'(clean_len)),
        .go         (go),
        .go_cnt     (go_cnt)
    );

    brq_gap_timer #(.GAP_CLKS(GAP_CLKS)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .start   (last_beat),
        .expired (gap_done)
    );

    assign mode_q    = mode;
    assign xfer_en   = (state == RQ_OWN) && bus_gnt;
    assign beat      = xfer_en && xfer_done;
    assign last_beat = beat && (remain == cnt_t'(1));
    assign bus_req_n = !((state == RQ_WAIT) || (state == RQ_OWN));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RQ_IDLE;
            remain  <= '0;
            own_end <= 1'b0;
        end else begin
            own_end <= 1'b0;
            case (state)
                RQ_IDLE: begin
                    if (go) begin
                        state  <= RQ_WAIT;
                        remain <= go_cnt;
                    end
                end
                RQ_WAIT: begin
                    if (bus_gnt) begin
                        state <= RQ_OWN;
                    end
                end
                RQ_OWN: begin
                    if (last_beat) begin
                        state   <= RQ_GAP;
                        remain  <= '0;
                        own_end <= 1'b1;
                    end else if (beat) begin
                        remain <= remain - 1'b1;
                    end else if (!bus_gnt) begin
                        state <= RQ_WAIT;
                    end
                end
                RQ_GAP: begin
                    if (gap_done) begin
                        if (go) begin
                            state  <= RQ_WAIT;
                            remain <= go_cnt;
                        end else begin
                            state <= RQ_IDLE;
                        end
                    end
                end
                default: state <= RQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/brq_checker.sv
module brq_checker
    import brq_pkg::*;
#(
    parameter int GAP_CLKS = 4
) (
    input logic clk,
    input logic rst,
    input logic bus_gnt,
    input logic xfer_done,
    input logic bus_req_n,
    input logic xfer_en,
    input logic own_end
);
    localparam int GW = $clog2(GAP_CLKS + 1);

    logic [GW-1:0] gap_left;
    cnt_t          beats;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_left <= '0;
            beats    <= '0;
        end else begin
            if (own_end) begin
                gap_left <= GW'(GAP_CLKS - 1);
            end else if (gap_left != '0) begin
                gap_left <= gap_left - 1'b1;
            end
            if (own_end) begin
                beats <= '0;
            end else if (xfer_en && xfer_done) begin
                beats <= beats + 1'b1;
            end
        end
    end

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (bus_req_n && !xfer_en && !own_end));

    // R6
    a_r6_en_needs_grant: assert property (@(posedge clk) disable iff (rst)
        xfer_en |-> (bus_gnt && !bus_req_n));

    // R7
    a_r7_release_at_end: assert property (@(posedge clk) disable iff (rst)
        own_end |-> bus_req_n);

    // R7
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        own_end |=> !own_end);

    // R8
    a_r8_fair_gap: assert property (@(posedge clk) disable iff (rst)
        (own_end || gap_left != '0) |-> bus_req_n);

    // R3
    a_r3_cap: assert property (@(posedge clk) disable iff (rst)
        own_end |-> (beats != '0 && beats <= cnt_t'(MAX_BURST)));

    // R9
    a_r9_hold_request: assert property (@(posedge clk) disable iff (rst)
        ($past(xfer_en && !xfer_done) && !bus_gnt) |-> (!bus_req_n && !xfer_en));
endmodule

bind dma_bus_requester brq_checker #(.GAP_CLKS(GAP_CLKS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_gnt   (bus_gnt),
    .xfer_done (xfer_done),
    .bus_req_n (bus_req_n),
    .xfer_en   (xfer_en),
    .own_end   (own_end)
);

// File: tb/sim_dma_bus_requester.sv
`timescale 1ns/1ps
module sim_dma_bus_requester;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_wdata = '0;
    logic [7:0] mode_q;
    logic       xfer_dir = 1'b0;
    logic [5:0] fifo_free = '0;
    logic [5:0] fifo_fill = '0;
    logic       clean_sof = 1'b0;
    logic       clean_eof = 1'b0;
    logic [4:0] clean_len = '0;
    logic       bus_gnt = 1'b0;
    logic       xfer_done = 1'b0;
    logic       bus_req_n;
    logic       xfer_en;
    logic       own_end;

    always #10 clk = ~clk;

    dma_bus_requester u0 (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .mode_q(mode_q), .xfer_dir(xfer_dir), .fifo_free(fifo_free),
        .fifo_fill(fifo_fill), .clean_sof(clean_sof), .clean_eof(clean_eof),
        .clean_len(clean_len), .bus_gnt(bus_gnt), .xfer_done(xfer_done),
        .bus_req_n(bus_req_n), .xfer_en(xfer_en), .own_end(own_end)
    );

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    int    exp_q[$];
    string tag_q[$];
    int    own_cnt = 0;
    int    xcnt = 0;
    int    last_gap = -1;
    int    hi = 0;
    bit    measuring = 0;
    bit    prev_beat = 0;
    bit    gnt_allow = 1'b1;
    bit    done_allow = 1'b1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic expect_own(input int n, input string tag);
        exp_q.push_back(n);
        tag_q.push_back(tag);
    endtask

    task automatic wait_own(input int target);
        while (own_cnt < target) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic write_mode(input logic [7:0] v);
        mode_wdata = v;
        mode_wr = 1'b1;
        step();
        mode_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // bus model: grant follows the request seen just after the edge
    always @(posedge clk) begin
        #1;
        bus_gnt = gnt_allow && !bus_req_n;
        xfer_done = done_allow;
    end

    // monitor: counts transfers per ownership and compares with the queue
    always @(negedge clk) begin
        if (!rst) begin
            if (own_end) begin
                int    e;
                string t;
                check(bus_req_n == 1'b1, "R7 request released at end", int'(bus_req_n), 1);
                check(prev_beat, "R7 end follows last transfer", int'(prev_beat), 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected ownership", xcnt, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(xcnt == e, t, xcnt, e);
                end
                own_cnt++;
                xcnt = 0;
                measuring = 1;
                hi = 1;
            end else if (measuring) begin
                if (bus_req_n) begin
                    hi++;
                end else begin
                    last_gap = hi;
                    measuring = 0;
                end
            end
            prev_beat = xfer_en && xfer_done;
            if (xfer_en && xfer_done) xcnt++;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int lows;
        step();
        step();
        step();
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(bus_req_n == 1'b1, "R1 bus_req_n after reset", int'(bus_req_n), 1);
        check(xfer_en == 1'b0, "R1 xfer_en after reset", int'(xfer_en), 0);
        check(own_end == 1'b0, "R1 own_end after reset", int'(own_end), 0);
        check(mode_q == 8'h00, "R1 mode after reset", int'(mode_q), 0);

        // R2 mode register: code 1 (4 transfers), option bits 101010
        step();
        write_mode(8'h6A);
        @(negedge clk);
        check(mode_q == 8'h6A, "R2 mode readback", int'(mode_q), 8'h6A);

        // R4 too little free space, direction 0
        step();
        xfer_dir = 1'b0;
        fifo_free = 6'd3;
        fifo_fill = 6'd40;
        lows = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!bus_req_n) lows++;
        end
        check(lows == 0, "R4 no request free<burst", lows, 0);

        // R4 direction 1 uses fill level
        step();
        xfer_dir = 1'b1;
        fifo_fill = 6'd3;
        fifo_free = 6'd40;
        lows = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!bus_req_n) lows++;
        end
        check(lows == 0, "R4 no request fill<burst", lows, 0);

        // R4 boundary: fill equals burst; R6 grant withheld first
        step();
        gnt_allow = 1'b0;
        fifo_free = 6'd0;
        fifo_fill = 6'd4;
        expect_own(4, "R3 code1 four transfers");
        step();
        step();
        step();
        @(negedge clk);
        check(bus_req_n == 1'b0, "R4 request at fill==burst", int'(bus_req_n), 0);
        check(xfer_en == 1'b0, "R6 no enable before grant", int'(xfer_en), 0);
        step();
        fifo_fill = 6'd0;
        gnt_allow = 1'b1;
        wait_own(1);
        step();
        xfer_dir = 1'b0;
        repeat (8) step();

        // R8 two ownerships back to back, measure the fairness gap
        fifo_free = 6'd20;
        expect_own(4, "R8 first burst");
        expect_own(4, "R8 second burst");
        wait_own(3);
        step();
        fifo_free = 6'd0;
        check(last_gap == 4, "R8 fairness gap length", last_gap, 4);
        repeat (8) step();

        // R3 the other burst codes
        write_mode(8'h00);
        fifo_free = 6'd16;
        expect_own(2, "R3 code0 two transfers");
        wait_own(4);
        step();
        fifo_free = 6'd0;
        repeat (6) step();

        write_mode(8'h80);
        fifo_free = 6'd16;
        expect_own(8, "R3 code2 eight transfers");
        wait_own(5);
        step();
        fifo_free = 6'd0;
        repeat (6) step();

        write_mode(8'hC0);
        fifo_free = 6'd16;
        expect_own(16, "R3 code3 sixteen transfers");
        wait_own(6);
        step();
        fifo_free = 6'd0;
        repeat (6) step();

        // R5 start cleanup with an empty FIFO, fewer than a burst
        write_mode(8'h80);
        clean_sof = 1'b1;
        clean_len = 5'd3;
        expect_own(3, "R5 start cleanup three transfers");
        wait_own(7);
        step();
        clean_sof = 1'b0;
        clean_len = 5'd0;
        repeat (6) step();

        // R5 end cleanup longer than the burst is capped
        write_mode(8'h00);
        clean_eof = 1'b1;
        clean_len = 5'd10;
        expect_own(2, "R5 end cleanup capped at burst");
        wait_own(8);
        step();
        clean_eof = 1'b0;
        clean_len = 5'd0;
        repeat (6) step();

        // R9 / R11 grant lost mid-burst, strobes keep coming
        write_mode(8'h80);
        fifo_free = 6'd16;
        expect_own(8, "R9 R11 total after regrant");
        while (xcnt < 3) begin
            @(negedge clk);
            #1;
        end
        step();
        fifo_free = 6'd0;
        gnt_allow = 1'b0;
        step();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(xfer_en == 1'b0, "R9 enable drops with grant", int'(xfer_en), 0);
            check(bus_req_n == 1'b0, "R9 request held after grant loss", int'(bus_req_n), 0);
            step();
        end
        gnt_allow = 1'b1;
        wait_own(9);
        step();
        repeat (6) step();

        // R10 mode change during ownership does not alter its count
        write_mode(8'h40);
        fifo_free = 6'd16;
        expect_own(4, "R10 count fixed at launch");
        while (xcnt < 1) begin
            @(negedge clk);
            #1;
        end
        fifo_free = 6'd0;
        write_mode(8'hC0);
        wait_own(10);
        step();
        repeat (8) step();
        @(negedge clk);
        check(mode_q == 8'hC0, "R10 mode write taken", int'(mode_q), 8'hC0);
        check(exp_q.size() == 0, "R3 all ownerships seen", exp_q.size(), 0);
        check(bus_req_n == 1'b1, "R4 idle at end", int'(bus_req_n), 1);
        finish_run();
    end

endmodule